// File: doc/BRIEF.md
# SPI Master Transfer Engine with Word-Addressed Buffer

This block is a pipelined bus slave that carries out SPI master transfers from a local buffer of 16-bit words. Software first writes the outgoing bytes into the buffer and programs two byte counts, one for sending and one for receiving. A write to the control register then starts the transfer. The engine clocks the send bytes out on MOSI. It then clocks the requested number of bytes in from MISO and writes them back into the same buffer, starting again at byte 0. Chip select stays low for the whole transfer.

While a transfer runs, the control register reads back non-zero. Every bus write is held off with stall until the transfer ends, and so is every buffer access. Software can therefore issue a write and use it as a wait for completion. Register reads are never held off.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck and spi_mosi are 0, bus_ack is 0, and the control register reads 0.
- R2: Word addresses 0 to 256*BLOCKS-1 are buffer words that can be read and written. The send count sits at word address 256*BLOCKS and the receive count at 256*BLOCKS+1. Each count keeps the low CNT_W bits of the written data (10 bits when BLOCKS=1) and reads back zero-extended.
- R3: A write of any value to word address 256*BLOCKS+2 or 256*BLOCKS+3 starts a transfer when at least one count is non-zero. When both counts are zero, such a write starts nothing.
- R4: A read of either control address returns 1 while a transfer is in progress and 0 otherwise.
- R5: bus_ack is 1 in exactly the cycle after each cycle in which bus_stb is 1 and bus_stall is 0, and is 0 otherwise. Read data is valid together with bus_ack.
- R6: During a transfer, every write and every buffer access is held with bus_stall. It completes after the transfer ends and does not cut the transfer short.
- R7: A read of a count or control address is never stalled.
- R8: The send phase emits buffer bytes 0 upward. Byte 2k is bits 7:0 of word k and byte 2k+1 is bits 15:8. Each byte goes out MSB first. spi_sck idles low, and spi_mosi changes only while spi_sck is low.
- R9: The receive phase follows the last send bit. spi_miso is sampled while spi_sck is high, and bytes are assembled MSB first. They are stored into buffer bytes 0 upward using the same packing. Bytes beyond the receive count keep their values.
- R10: spi_sck runs at clk/4, two cycles high and two cycles low. spi_cs_n is low without a break for exactly 32*(send+receive) cycles, with 8 spi_sck rising edges per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_stb | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | ADDR_W | Word address ($clog2(BLOCKS+1)+8 bits) |
| bus_wdat | input | 16 | Write data |
| bus_rdat | output | 16 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Request completion |
| bus_stall | output | 1 | Request not accepted this cycle |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
A request completes on the clock edge where bus_stb is high and bus_stall is low. bus_ack and the read data are due one edge after that, so the bench samples them one time unit after that edge. bus_stall is combinational and is sampled mid-cycle before every edge. Serial results are due 4 cycles per bit and 32 per byte from the edge that accepts the start write. The bench counts spi_cs_n low cycles and spi_sck edges instead of waiting fixed delays. It then reads the buffer only after the control register has read back 0.

// File: rtl/spi_xfer_pkg.sv
// Shared constants, state encoding and byte-lane helper for the SPI transfer engine.
// Assumes a 16-bit bus word split into two byte lanes.
package spi_xfer_pkg;
    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int LANES    = WORD_W / BYTE_W;
    localparam int SCK_DIV  = 4;
    localparam int WORDS_PER_BLOCK = 256;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_TX   = 2'd1,
        ENG_RX   = 2'd2
    } eng_state_t;

    // Pick one byte lane of a buffer word
    function automatic logic [BYTE_W-1:0] lane_of(input logic [WORD_W-1:0] word,
                                                  input logic hi);
        return hi ? word[2*BYTE_W-1:BYTE_W] : word[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/xfer_buffer.sv
// Transfer buffer: one write port with byte-lane enables, two asynchronous read ports.
// Assumes a synchronous-write, asynchronous-read memory; contents are not reset.
module xfer_buffer
    import spi_xfer_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [AW-1:0]     rd_a_addr,
    output logic [WORD_W-1:0] rd_a_data,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [WORD_W-1:0] rd_b_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] store [DEPTH];

        // Write the selected byte lane
        always_ff @(posedge clk) begin
            if (wr_en && wr_lane[g]) begin
                store[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
            end
        end

        assign rd_a_data[g*BYTE_W +: BYTE_W] = store[rd_a_addr];
        assign rd_b_data[g*BYTE_W +: BYTE_W] = store[rd_b_addr];
    end
endmodule

// File: rtl/xfer_bus_slave.sv
// Bus side: address decode, stall rule, registered acknowledge and read data,
// the two byte-count registers and the start pulse.
// Assumes the caller routes buffer writes away from the engine only while idle.
module xfer_bus_slave
    import spi_xfer_pkg::*;
#(
    parameter int BLOCKS = 1,
    parameter int ADDR_W = $clog2(BLOCKS + 1) + 8,
    parameter int MEM_AW = $clog2(WORDS_PER_BLOCK * BLOCKS),
    parameter int CNT_W  = $clog2(2 * WORDS_PER_BLOCK * BLOCKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_adr,
    input  logic [WORD_W-1:0] bus_wdat,
    output logic [WORD_W-1:0] bus_rdat,
    output logic              bus_ack,
    output logic              bus_stall,
    input  logic              busy,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic [CNT_W-1:0]  rx_cnt,
    output logic              start
);
    localparam int MEM_WORDS = WORDS_PER_BLOCK * BLOCKS;
    localparam logic [ADDR_W-1:0] REG_TX   = ADDR_W'(MEM_WORDS);
    localparam logic [ADDR_W-1:0] REG_RX   = ADDR_W'(MEM_WORDS + 1);
    localparam logic [ADDR_W-1:0] REG_CTL0 = ADDR_W'(MEM_WORDS + 2);
    localparam logic [ADDR_W-1:0] REG_CTL1 = ADDR_W'(MEM_WORDS + 3);

    logic is_mem, is_tx, is_rx, is_ctl, accept;
    logic [WORD_W-1:0] rd_next;

    assign is_mem = bus_adr < REG_TX;
    assign is_tx  = bus_adr == REG_TX;
    assign is_rx  = bus_adr == REG_RX;
    assign is_ctl = (bus_adr == REG_CTL0) || (bus_adr == REG_CTL1);

    // Hold writes and buffer accesses while a transfer is running
    assign bus_stall = bus_stb && busy && (bus_we || is_mem);
    assign accept    = bus_stb && !bus_stall;

    assign start    = accept && bus_we && is_ctl;
    assign mem_we   = accept && bus_we && is_mem;
    assign mem_addr = bus_adr[MEM_AW-1:0];

    // Select the value returned by a read
    always_comb begin
        rd_next = '0;
        if (is_mem)      rd_next = mem_rdata;
        else if (is_tx)  rd_next = WORD_W'(tx_cnt);
        else if (is_rx)  rd_next = WORD_W'(rx_cnt);
        else if (is_ctl) rd_next = WORD_W'(busy);
    end

    // Acknowledge, read data and count register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack  <= 1'b0;
            bus_rdat <= '0;
            tx_cnt   <= '0;
            rx_cnt   <= '0;
        end else begin
            bus_ack <= accept;
            if (accept && !bus_we) bus_rdat <= rd_next;
            if (accept && bus_we && is_tx) tx_cnt <= CNT_W'(bus_wdat);
            if (accept && bus_we && is_rx) rx_cnt <= CNT_W'(bus_wdat);
        end
    end
endmodule

// File: rtl/xfer_shifter.sv
// Serial engine: sends tx_cnt buffer bytes MSB first, then receives rx_cnt bytes
// into the buffer from byte 0. SPI mode 0 at clk/SCK_DIV; chip select spans both phases.
// Assumes the count registers do not change while busy (bus writes are stalled).
module xfer_shifter
    import spi_xfer_pkg::*;
#(
    parameter int MEM_AW = 8,
    parameter int CNT_W  = MEM_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              spi_miso,
    output logic              busy,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_lane
);
    localparam int PH_W = $clog2(SCK_DIV);
    localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SCK_DIV / 2);
    localparam logic [PH_W-1:0] PH_LAST   = PH_W'(SCK_DIV - 1);

    eng_state_t        state;
    logic [PH_W-1:0]   ph;
    logic [2:0]        bitn;
    logic [CNT_W-1:0]  byten;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] cur_byte;
    logic [CNT_W-1:0]  cur_cnt;
    logic              bit_end, byte_end, last_byte;

    assign busy     = state != ENG_IDLE;
    assign spi_cs_n = !busy;
    assign spi_sck  = busy && (ph >= PH_SAMPLE);

    assign mem_addr  = byten[MEM_AW:1];
    assign cur_byte  = lane_of(mem_rdata, byten[0]);
    assign spi_mosi  = (state == ENG_TX) ? cur_byte[3'd7 - bitn] : 1'b0;

    assign bit_end   = ph == PH_LAST;
    assign byte_end  = bit_end && (bitn == 3'd7);
    assign cur_cnt   = (state == ENG_TX) ? tx_cnt : rx_cnt;
    assign last_byte = (byten + CNT_W'(1)) == cur_cnt;

    assign mem_we    = (state == ENG_RX) && byte_end;
    assign mem_wdata = {rx_sh, rx_sh};
    assign mem_lane  = byten[0] ? LANES'(2) : LANES'(1);

    // Phase, bit and byte sequencing and the receive shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_IDLE;
            ph    <= '0;
            bitn  <= '0;
            byten <= '0;
            rx_sh <= '0;
        end else if (state == ENG_IDLE) begin
            if (start) begin
                ph    <= '0;
                bitn  <= '0;
                byten <= '0;
                if (tx_cnt != '0)      state <= ENG_TX;
                else if (rx_cnt != '0) state <= ENG_RX;
            end
        end else begin
            ph <= bit_end ? '0 : ph + PH_W'(1);
            if (state == ENG_RX && ph == PH_SAMPLE) begin
                rx_sh <= {rx_sh[BYTE_W-2:0], spi_miso};
            end
            if (bit_end) begin
                bitn <= bitn + 3'd1;
                if (bitn == 3'd7) begin
                    if (last_byte) begin
                        byten <= '0;
                        if (state == ENG_TX && rx_cnt != '0) state <= ENG_RX;
                        else                                 state <= ENG_IDLE;
                    end else begin
                        byten <= byten + CNT_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_xfer_engine.sv
// Top level: bus slave, serial engine and the shared transfer buffer.
// The engine owns the buffer write port while busy; the bus owns it otherwise.
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int BLOCKS = 1,
    parameter int ADDR_W = $clog2(BLOCKS + 1) + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_adr,
    input  logic [15:0]       bus_wdat,
    output logic [15:0]       bus_rdat,
    output logic              bus_ack,
    output logic              bus_stall,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    localparam int MEM_WORDS = WORDS_PER_BLOCK * BLOCKS;
    localparam int MEM_AW    = $clog2(MEM_WORDS);
    localparam int CNT_W     = $clog2(2 * MEM_WORDS + 1);

    logic              busy, start;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [MEM_AW-1:0] bus_mem_addr, eng_mem_addr, buf_waddr;
    logic              bus_mem_we, eng_mem_we, buf_we;
    logic [WORD_W-1:0] eng_wdata, buf_wdata, bus_mem_rdata, eng_mem_rdata;
    logic [LANES-1:0]  eng_lane, buf_lane;

    xfer_bus_slave #(
        .BLOCKS(BLOCKS), .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .CNT_W(CNT_W)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdat(bus_wdat),
        .bus_rdat(bus_rdat), .bus_ack(bus_ack), .bus_stall(bus_stall),
        .busy(busy), .mem_rdata(bus_mem_rdata), .mem_addr(bus_mem_addr),
        .mem_we(bus_mem_we), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .start(start)
    );

    xfer_shifter #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .mem_rdata(eng_mem_rdata),
        .spi_miso(spi_miso), .busy(busy), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .mem_addr(eng_mem_addr), .mem_we(eng_mem_we),
        .mem_wdata(eng_wdata), .mem_lane(eng_lane)
    );

    // Buffer write port ownership follows the busy flag
    assign buf_we    = busy ? eng_mem_we   : bus_mem_we;
    assign buf_waddr = busy ? eng_mem_addr : bus_mem_addr;
    assign buf_wdata = busy ? eng_wdata    : bus_wdat;
    assign buf_lane  = busy ? eng_lane     : '1;

    xfer_buffer #(.DEPTH(MEM_WORDS), .AW(MEM_AW)) u_buf (
        .clk(clk), .wr_en(buf_we), .wr_addr(buf_waddr), .wr_data(buf_wdata),
        .wr_lane(buf_lane), .rd_a_addr(bus_mem_addr), .rd_a_data(bus_mem_rdata),
        .rd_b_addr(eng_mem_addr), .rd_b_data(eng_mem_rdata)
    );
endmodule

// File: rtl/spi_xfer_engine_chk.sv
// Port-level protocol checker for spi_xfer_engine, attached with bind.
module spi_xfer_engine_chk #(
    parameter int BLOCKS = 1,
    parameter int ADDR_W = $clog2(BLOCKS + 1) + 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_stb,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_adr,
    input logic              bus_ack,
    input logic              bus_stall,
    input logic              spi_sck,
    input logic              spi_mosi,
    input logic              spi_cs_n
);
    localparam logic [ADDR_W-1:0] REG_FIRST = ADDR_W'(256 * BLOCKS);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (spi_cs_n && !bus_ack && !spi_sck)); // R1
    AST_ACK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !bus_stall) |=> bus_ack); // R5
    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_stb && !bus_stall) |=> !bus_ack); // R5
    AST_WRITE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_we && !spi_cs_n) |-> bus_stall); // R6
    AST_REG_READ_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !bus_we && bus_adr >= REG_FIRST) |-> !bus_stall); // R7
    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi)); // R8
    AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R10
    AST_SCK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |=> spi_sck); // R10
    AST_SCK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_sck) && !spi_cs_n) |=> !spi_sck); // R10
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.BLOCKS(BLOCKS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_ack(bus_ack), .bus_stall(bus_stall), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/spi_xfer_engine_tb.sv
// Self-checking bench: buffer sweep, count registers, a send/receive count sweep
// against a bench serial peer, and stall behaviour during transfers.
module spi_xfer_engine_tb;
    localparam int BLOCKS    = 1;
    localparam int ADDR_W    = $clog2(BLOCKS + 1) + 8;
    localparam int MEM_WORDS = 256 * BLOCKS;
    localparam int REG_TX    = MEM_WORDS;
    localparam int REG_RX    = MEM_WORDS + 1;
    localparam int REG_CTL   = MEM_WORDS + 2;
    localparam int REG_CTL2  = MEM_WORDS + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_stb = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_adr = '0;
    logic [15:0] bus_wdat = '0;
    logic [15:0] bus_rdat;
    logic bus_ack, bus_stall, spi_sck, spi_mosi, spi_miso, spi_cs_n;

    int checks = 0;
    int fails  = 0;
    int cur_tx = 0;
    int cur_seed = 0;
    int fall_cnt = 0;
    int rise_cnt = 0;
    int cs_low = 0;
    logic mosi_bits [0:8191];

    always #4 clk = ~clk;

    spi_xfer_engine #(.BLOCKS(BLOCKS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat),
        .bus_ack(bus_ack), .bus_stall(bus_stall), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    function automatic int txb(input int seed, input int j);
        return (j * 29 + seed * 13 + 5) & 255;
    endfunction
    function automatic int rxb(input int seed, input int j);
        return (j * 53 + seed * 7 + 90) & 255;
    endfunction

    // Serial peer: next bit presented after each falling SCK edge
    always @(negedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) fall_cnt <= 0;
        else          fall_cnt <= fall_cnt + 1;
    end
    always_comb begin
        int k;
        k = fall_cnt - 8 * cur_tx;
        if (k < 0) spi_miso = 1'b0;
        else       spi_miso = rxb(cur_seed, k / 8)[7 - (k % 8)];
    end
    // Record MOSI at each rising SCK edge
    always @(posedge spi_sck) begin
        mosi_bits[rise_cnt % 8192] <= spi_mosi;
        rise_cnt <= rise_cnt + 1;
    end
    // Count chip-select low cycles
    always @(negedge clk) if (!spi_cs_n) cs_low <= cs_low + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_op(input bit we, input int adr, input int wdat,
                          output int rdat, output int stalls);
        @(negedge clk);
        bus_stb = 1'b1; bus_we = we; bus_adr = ADDR_W'(adr); bus_wdat = 16'(wdat);
        stalls = 0;
        #1;
        while (bus_stall) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        bus_stb = 1'b0; bus_we = 1'b0;
        chk(bus_ack == 1'b1, "R5 ack one cycle after accept", int'(bus_ack), 1);
        rdat = int'(bus_rdat);
    endtask

    task automatic wr(input int adr, input int dat);
        int r, s;
        bus_op(1'b1, adr, dat, r, s);
    endtask
    task automatic rd(input int adr, output int dat, output int stalls);
        bus_op(1'b0, adr, 0, dat, stalls);
    endtask

    task automatic load_buf(input int seed);
        for (int w = 0; w < 4; w++) wr(w, txb(seed, 2 * w) | (txb(seed, 2 * w + 1) << 8));
    endtask

    task automatic wait_idle();
        int v, s, n;
        n = 0;
        do begin
            rd(REG_CTL, v, s);
            n++;
        end while (v != 0 && n < 1000);
    endtask

    // One transfer with full result checking
    task automatic run_xfer(input int tx, input int rx, input int seed, input int ctl);
        int v, s, rbase, cbase, got, expb;
        load_buf(seed);
        wr(REG_TX, tx);
        wr(REG_RX, rx);
        cur_tx = tx; cur_seed = seed;
        rbase = rise_cnt; cbase = cs_low;
        wr(ctl, seed * 4099);
        rd(REG_CTL, v, s);
        chk((v != 0) == (tx + rx != 0), "R3/R4 busy after start", v, (tx + rx != 0) ? 1 : 0);
        wait_idle();
        chk(cs_low - cbase == 32 * (tx + rx), "R10 cs low cycles", cs_low - cbase, 32 * (tx + rx));
        chk(rise_cnt - rbase == 8 * (tx + rx), "R10 sck rising edges", rise_cnt - rbase, 8 * (tx + rx));
        for (int j = 0; j < tx; j++) begin
            got = 0;
            for (int b = 0; b < 8; b++) got = (got << 1) | int'(mosi_bits[(rbase + 8 * j + b) % 8192]);
            chk(got == txb(seed, j), "R8 mosi byte", got, txb(seed, j));
        end
        for (int w = 0; w < 4; w++) begin
            rd(w, v, s);
            for (int h = 0; h < 2; h++) begin
                expb = (2 * w + h < rx) ? rxb(seed, 2 * w + h) : txb(seed, 2 * w + h);
                chk(((v >> (8 * h)) & 255) == expb, "R9 buffer byte after receive",
                    (v >> (8 * h)) & 255, expb);
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v, s, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 cs_n after reset", int'(spi_cs_n), 1);
        chk(spi_sck == 1'b0, "R1 sck after reset", int'(spi_sck), 0);
        chk(spi_mosi == 1'b0, "R1 mosi after reset", int'(spi_mosi), 0);
        chk(bus_ack == 1'b0, "R1 ack after reset", int'(bus_ack), 0);
        rd(REG_CTL, v, s);
        chk(v == 0, "R1 control reads zero", v, 0);

        // R2: whole buffer write then read back
        for (int a = 0; a < MEM_WORDS; a++) wr(a, (a * 257) ^ 16'h3C5A);
        for (int a = 0; a < MEM_WORDS; a++) begin
            rd(a, v, s);
            chk(v == (((a * 257) ^ 16'h3C5A) & 16'hFFFF), "R2 buffer word", v, ((a * 257) ^ 16'h3C5A) & 16'hFFFF);
        end
        wr(REG_TX, 16'hFFFF);
        rd(REG_TX, v, s);
        chk(v == 16'h03FF, "R2 send count truncated", v, 16'h03FF);
        wr(REG_RX, 16'h0123);
        rd(REG_RX, v, s);
        chk(v == 16'h0123, "R2 receive count", v, 16'h0123);

        // R3, R8, R9, R10: sweep of send and receive counts, both control addresses
        for (int t = 0; t < 5; t++)
            for (int r = 0; r < 4; r++)
                run_xfer(t, r, t * 4 + r + 1, ((t + r) % 2 == 1) ? REG_CTL2 : REG_CTL);

        // R6, R7: reads and writes issued during a transfer
        load_buf(9);
        wr(REG_TX, 2);
        wr(REG_RX, 1);
        cur_tx = 2; cur_seed = 9;
        c0 = cs_low;
        wr(REG_CTL, 0);
        rd(REG_CTL, v, s);
        chk(s == 0, "R7 control read not stalled", s, 0);
        chk(v == 1, "R4 control reads one while busy", v, 1);
        rd(REG_TX, v, s);
        chk(s == 0, "R7 count read not stalled", s, 0);
        rd(0, v, s);
        chk(s > 0, "R6 buffer read stalled", s, 1);
        chk(spi_cs_n == 1'b1, "R6 buffer read done after transfer", int'(spi_cs_n), 1);
        chk(v == (rxb(9, 0) | (txb(9, 1) << 8)), "R9 first word after receive", v, rxb(9, 0) | (txb(9, 1) << 8));
        c0 = cs_low;
        wr(REG_CTL, 16'h5555);
        wr(REG_RX, 2);
        chk(spi_cs_n == 1'b1, "R6 write completes after transfer", int'(spi_cs_n), 1);
        chk(cs_low - c0 == 96, "R6 stalled write leaves transfer whole", cs_low - c0, 96);
        rd(REG_RX, v, s);
        chk(v == 2, "R6 stalled write took effect", v, 2);
        rd(REG_CTL2, v, s);
        chk(v == 0, "R4 alias reads zero when idle", v, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule